// File: doc/BRIEF.md
# Frame Sync Detector with Flywheel

This block sits behind a data-recovery PLL and receives the recovered serial channel bits. Each bit comes with a one-cycle valid strobe. It looks in the bit stream for the frame sync word: a run of ones followed by an equal-length run of zeros. Once it has seen two sync words exactly one frame apart, it runs its own frame timing. That timing keeps turning through sync words that are missing or corrupted.

While locked, a sync word is accepted only within one bit of where the timing expects it, and a sync word found anywhere else is ignored. When no sync word falls in that window, a frame start is still produced at the expected bit. If too many frames in a row pass without an accepted sync, lock is dropped and a fresh search begins.

Downstream logic uses `frame_start_o` as the symbol-framing reference and `locked_o` as a quality flag. `sync_match_o` marks frames whose detected sync landed exactly on the internal timing. With the defaults, a frame is 588 channel bits and the sync word is eleven ones followed by eleven zeros.

Top module: `fsd_frame_sync`

## Requirements
- R1: While `rst_ni` is low, and directly after reset, `locked_o`, `frame_start_o` and `sync_match_o` are all 0.
- R2: A sync is detected on the valid bit that completes SYNC_ONES ones followed by SYNC_ZEROS zeros, the oldest bit first. Bits offered while `bit_vld_i` is low are not shifted in and have no effect.
- R3: Lock is declared when a sync ends exactly FRAME_BITS valid bits after the previous one. `frame_start_o` and `sync_match_o` pulse on that bit. A sync at any other spacing restarts the confirmation from the later sync, and no sync by the FRAME_BITS-th bit returns the block to search.
- R4: While locked, a sync ending exactly FRAME_BITS valid bits after the current frame reference pulses both `frame_start_o` and `sync_match_o`.
- R5: While locked, a sync one bit early is accepted: `frame_start_o` pulses on that bit without `sync_match_o`. A sync one bit late produces no extra pulse, because the frame start was already given on the expected bit, but it realigns the frame reference to itself.
- R6: While locked, if no sync arrives by the expected bit, `frame_start_o` is still pulsed on that bit and the frame timing continues from it.
- R7: While locked, a sync outside the one-bit window produces no pulse and does not move the frame timing.
- R8: After MISS_LIMIT consecutive frames with no accepted sync, `locked_o` falls on the valid bit that follows the last inserted frame start, and search restarts.
- R9: Outputs are registered. They update on the clock edge that takes a valid bit, `frame_start_o` and `sync_match_o` are single-cycle pulses, and neither pulses on a cycle without a valid bit.
- R10: Any accepted sync clears the count of consecutive missed frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Recovered channel bit |
| bit_vld_i | input | 1 | Strobe marking `bit_i` as a new channel bit |
| frame_start_o | output | 1 | One-cycle pulse at each frame reference |
| locked_o | output | 1 | Frame timing is locked |
| sync_match_o | output | 1 | One-cycle pulse when the detected sync coincides with the internal timing |

## Verification
The bench sweeps a sync word shifted from -3 to +3 bits against the expected position. At ±1 it must be accepted, and a design with an off-by-one window would either insert a frame or keep a stale reference. At ±2 and ±3 it must be ignored, and a window that is too wide would silently jump phase. Runs of missed frames broken by a single good sync check that the miss count clears, where a sticky counter would drop lock early. A final run of missed frames checks that lock falls on the exact bit after the last inserted frame. The cases are repeated with idle cycles between valid bits, with garbage on `bit_i` during those idle cycles, to catch a detector that shifts unstrobed bits.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } fsd_state_e;
endpackage

// File: rtl/fsd_sync_match.sv
module fsd_sync_match #(
  parameter int SYNC_ONES  = 11,
  parameter int SYNC_ZEROS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_vld_i,
  output logic hit_o
);
  localparam int PW = SYNC_ONES + SYNC_ZEROS;
  localparam int HW = PW - 1;
  localparam logic [PW-1:0] PAT = {{SYNC_ONES{1'b1}}, {SYNC_ZEROS{1'b0}}};

  logic [HW-1:0] hist_q;
  logic [PW-1:0] win;

  assign win   = {hist_q, bit_i};
  assign hit_o = bit_vld_i && (win == PAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hist_q <= '0;
    else if (bit_vld_i) hist_q <= win[HW-1:0];
  end
endmodule

// File: rtl/fsd_bit_ctr.sv
module fsd_bit_ctr #(
  parameter int FRAME_BITS = 588,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             on_exp_o,
  output logic             on_early_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;

  assign cnt_inc    = cnt_q + CNT_W'(1);
  assign on_exp_o   = (cnt_inc == CNT_W'(FRAME_BITS));
  assign on_early_o = (cnt_inc == CNT_W'(FRAME_BITS - 1));
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= clr_i ? '0 : cnt_inc;
  end
endmodule

// File: rtl/fsd_lock_ctrl.sv
module fsd_lock_ctrl
  import fsd_pkg::*;
#(
  parameter int FRAME_BITS = 588,
  parameter int MISS_LIMIT = 8,
  localparam int CNT_W  = $clog2(FRAME_BITS + 1),
  localparam int MISS_W = $clog2(MISS_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             hit_i,
  input  logic             on_exp_i,
  input  logic             on_early_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clr_o,
  output logic             frame_start_o,
  output logic             locked_o,
  output logic             sync_match_o
);
  fsd_state_e        st_q, st_n;
  logic [MISS_W-1:0] miss_q, miss_n, miss_inc;
  logic              late_q, late_n;
  logic              fs_q, fs_n, mt_q, mt_n;

  assign miss_inc = miss_q + MISS_W'(1);

  always_comb begin
    st_n   = st_q;
    miss_n = miss_q;
    late_n = late_q;
    fs_n   = 1'b0;
    mt_n   = 1'b0;
    clr_o  = 1'b0;
    if (vld_i) begin
      unique case (st_q)
        ST_SEARCH: begin
          clr_o = 1'b1;
          if (hit_i) st_n = ST_CONFIRM;
        end
        ST_CONFIRM: begin
          if (hit_i) begin
            clr_o = 1'b1;
            if (on_exp_i) begin
              st_n   = ST_LOCKED;
              fs_n   = 1'b1;
              mt_n   = 1'b1;
              miss_n = '0;
              late_n = 1'b0;
            end
          end else if (on_exp_i) begin
            st_n = ST_SEARCH;
          end
        end
        ST_LOCKED: begin
          if (late_q) begin
            // bit after an inserted frame start: last chance for a late sync
            late_n = 1'b0;
            if (hit_i) begin
              clr_o  = 1'b1;
              miss_n = '0;
            end else if (miss_inc == MISS_W'(MISS_LIMIT)) begin
              st_n   = ST_SEARCH;
              miss_n = '0;
            end else begin
              miss_n = miss_inc;
            end
          end else if (hit_i && on_early_i) begin
            fs_n   = 1'b1;
            clr_o  = 1'b1;
            miss_n = '0;
          end else if (hit_i && on_exp_i) begin
            fs_n   = 1'b1;
            mt_n   = 1'b1;
            clr_o  = 1'b1;
            miss_n = '0;
          end else if (on_exp_i) begin
            fs_n   = 1'b1;
            clr_o  = 1'b1;
            late_n = 1'b1;
          end
        end
        default: st_n = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SEARCH;
      miss_q <= '0;
      late_q <= 1'b0;
      fs_q   <= 1'b0;
      mt_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      miss_q <= miss_n;
      late_q <= late_n;
      fs_q   <= fs_n;
      mt_q   <= mt_n;
    end
  end

  assign frame_start_o = fs_q;
  assign sync_match_o  = mt_q;
  assign locked_o      = (st_q == ST_LOCKED);

  // R9
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |=> !fs_q);
  // R9
  pulse_strobed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |-> $past(vld_i));
  // R3
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> fs_q && mt_q);
  // R4
  match_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mt_q |-> locked_o && fs_q);
  // R8
  miss_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q < MISS_W'(MISS_LIMIT));
  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_SEARCH) |-> (cnt_i < CNT_W'(FRAME_BITS)));
  // R5
  late_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_q |-> locked_o);
endmodule

// File: rtl/fsd_frame_sync.sv
module fsd_frame_sync #(
  parameter int FRAME_BITS = 588,
  parameter int SYNC_ONES  = 11,
  parameter int SYNC_ZEROS = 11,
  parameter int MISS_LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_vld_i,
  output logic frame_start_o,
  output logic locked_o,
  output logic sync_match_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic             hit, clr, on_exp, on_early;
  logic [CNT_W-1:0] cnt;

  fsd_sync_match #(
    .SYNC_ONES (SYNC_ONES),
    .SYNC_ZEROS(SYNC_ZEROS)
  ) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_i    (bit_i),
    .bit_vld_i(bit_vld_i),
    .hit_o    (hit)
  );

  fsd_bit_ctr #(
    .FRAME_BITS(FRAME_BITS)
  ) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (bit_vld_i),
    .clr_i     (clr),
    .cnt_o     (cnt),
    .on_exp_o  (on_exp),
    .on_early_o(on_early)
  );

  fsd_lock_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .MISS_LIMIT(MISS_LIMIT)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vld_i        (bit_vld_i),
    .hit_i        (hit),
    .on_exp_i     (on_exp),
    .on_early_i   (on_early),
    .cnt_i        (cnt),
    .clr_o        (clr),
    .frame_start_o(frame_start_o),
    .locked_o     (locked_o),
    .sync_match_o (sync_match_o)
  );
endmodule

// File: tb/fsd_frame_sync_tb_top.sv
module fsd_frame_sync_tb_top;
  localparam int F    = 40;
  localparam int ON   = 4;
  localparam int OFF  = 4;
  localparam int ML   = 3;
  localparam int MAXL = 1024;

  logic clk = 1'b0, rst_n = 1'b0, bit_d = 1'b0, vld = 1'b0;
  logic fs, lk, mt;

  always #2 clk = ~clk;

  fsd_frame_sync #(.FRAME_BITS(F), .SYNC_ONES(ON), .SYNC_ZEROS(OFF), .MISS_LIMIT(ML)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_d), .bit_vld_i(vld),
    .frame_start_o(fs), .locked_o(lk), .sync_match_o(mt));

  int errs = 0, chks = 0;
  bit done = 1'b0;
  bit strm [MAXL];
  bit syn  [MAXL];
  int slen;
  int m_st, m_cnt, m_miss;
  bit m_late;

  task automatic chk(string req, string what, int act, int exp);
    chks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  endtask

  task automatic do_reset();
    vld = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "locked in reset", lk, 0);
    chk("R1", "frame_start in reset", fs, 0);
    chk("R1", "match in reset", mt, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "locked after reset", lk, 0);
    m_st = 0; m_cnt = 0; m_miss = 0; m_late = 1'b0;
  endtask

  task automatic clear_stream(int len);
    slen = len;
    for (int i = 0; i < MAXL; i++) begin strm[i] = bit'(i % 2); syn[i] = 1'b0; end
  endtask

  task automatic put_sync(int e);
    for (int k = 0; k < ON; k++)  strm[e - ON - OFF + 1 + k] = 1'b1;
    for (int k = 0; k < OFF; k++) strm[e - OFF + 1 + k] = 1'b0;
    syn[e] = 1'b1;
  endtask

  // requirement-level reference: outputs expected after one valid bit
  task automatic model_step(bit det, output bit efs, output bit emt, output string tag);
    int inc;
    inc = m_cnt + 1; efs = 0; emt = 0; tag = "R7";
    case (m_st)
      0: begin tag = "R2"; if (det) begin m_st = 1; m_cnt = 0; end end
      1: begin
        tag = "R3";
        if (det) begin
          if (inc == F) begin m_st = 2; efs = 1; emt = 1; m_miss = 0; m_late = 0; end
          m_cnt = 0;
        end else if (inc == F) m_st = 0;
        else m_cnt = inc;
      end
      default: begin
        if (m_late) begin
          m_late = 0;
          if (det) begin tag = (m_miss != 0) ? "R10" : "R5"; m_cnt = 0; m_miss = 0; end
          else begin
            tag = "R8"; m_cnt = inc;
            if (m_miss + 1 == ML) begin m_st = 0; m_miss = 0; end else m_miss++;
          end
        end else if (det && inc == F - 1) begin
          tag = (m_miss != 0) ? "R10" : "R5"; efs = 1; m_cnt = 0; m_miss = 0;
        end else if (det && inc == F) begin
          tag = (m_miss != 0) ? "R10" : "R4"; efs = 1; emt = 1; m_cnt = 0; m_miss = 0;
        end else if (inc == F) begin
          tag = "R6"; efs = 1; m_cnt = 0; m_late = 1;
        end else m_cnt = inc;
      end
    endcase
  endtask

  task automatic run(int gap);
    bit efs, emt;
    string tag;
    for (int i = 0; i < slen; i++) begin
      if (gap > 0 && (i % gap) == gap - 1) begin
        @(negedge clk) begin vld = 1'b0; bit_d = ~strm[i]; end
        @(posedge clk); #1;
        chk("R9", "frame_start on idle cycle", fs, 0);
        chk("R9", "match on idle cycle", mt, 0);
        chk("R2", "locked on idle cycle", lk, (m_st == 2) ? 1 : 0);
      end
      @(negedge clk) begin vld = 1'b1; bit_d = strm[i]; end
      @(posedge clk); #1;
      model_step(syn[i], efs, emt, tag);
      chk(tag, $sformatf("frame_start bit %0d", i), fs, efs);
      chk(tag, $sformatf("match bit %0d", i), mt, emt);
      chk(tag, $sformatf("locked bit %0d", i), lk, (m_st == 2) ? 1 : 0);
    end
    @(negedge clk) vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; chks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    // R3 R4: clean frames
    do_reset();
    clear_stream(460);
    for (int k = 0; k <= 10; k++) put_sync(39 + F * k);
    run(0);
    chk("R3", "locked after clean frames", lk, 1);

    // R6 R10 R2: two missing syncs, idle strobes with garbage on bit_i
    do_reset();
    clear_stream(460);
    for (int k = 0; k <= 10; k++) if (k != 4 && k != 5) put_sync(39 + F * k);
    run(3);
    chk("R6", "locked through flywheel", lk, 1);

    // R5 R7 R8: phase step sweep
    for (int off = -3; off <= 3; off++) begin
      do_reset();
      clear_stream(480);
      put_sync(39); put_sync(79); put_sync(119);
      for (int j = 0; j < 8; j++) if (159 + off + F * j < 480) put_sync(159 + off + F * j);
      run((off == 2) ? 4 : 0);
      chk((off >= -1 && off <= 1) ? "R5" : "R8", $sformatf("relocked after step %0d", off), lk, 1);
    end

    // R7 R10 R8: false sync mid-frame, broken miss runs, then total loss
    do_reset();
    clear_stream(700);
    put_sync(39); put_sync(79); put_sync(119); put_sync(139); put_sync(159);
    put_sync(199); put_sync(239); put_sync(359); put_sync(479); put_sync(519);
    run(0);
    chk("R8", "lock lost after silence", lk, 0);

    // R3: wrong spacing restarts confirmation
    do_reset();
    clear_stream(200);
    put_sync(39); put_sync(75); put_sync(115); put_sync(155); put_sync(195);
    run(0);
    chk("R3", "locked after re-anchor", lk, 1);

    // R5: early then late chain
    do_reset();
    clear_stream(280);
    put_sync(39); put_sync(79); put_sync(119); put_sync(158); put_sync(199); put_sync(239);
    run(5);
    chk("R5", "locked after early/late", lk, 1);

    finish_run();
  end
endmodule